// File: doc/BRIEF.md
# Guarded Processor Status Word

This block holds the 16-bit status word of a processor core. The low byte keeps the result flags: carry, trace enable, unsigned-less, a general flag, equal and signed-less, plus two bits kept for the core's own use. The high byte keeps the mode bits: user mode, stack select, trace pending and interrupt enable. The four top bits are never stored.

The execution unit drives the block. It can write either byte, report a compare of two operands, report the carry or borrow of an add or subtract, and signal entry into an interrupt or trap. A compare is either integer, where the block derives the flags from the operand values, or floating point, where the block takes a precomputed equal/less pair. The block guards the high byte: a write to it has effect only in supervisor mode. The block also decides, without a clock delay, whether a maskable or a non-maskable interrupt request is accepted.

Top module: `psw_guard`

## Requirements
- R1: After reset the status word `psw` and `priv_fault` are all zero. The bit positions are: carry 0, trace 1, unsigned-less 2, spare 3 and 4, general flag 5, equal 6, signed-less 7, user mode 8, stack select 9, trace pending 10, interrupt enable 11.
- R2: When `wr_lo_en` is high, bits 7:0 of `psw` take `wr_data[7:0]` on the next edge. This holds in either mode.
- R3: When `wr_hi_en` is high and the user bit (8) is 0, bits 11:8 take `wr_data[11:8]`. Bits 15:12 of `psw` always read 0.
- R4: When `wr_hi_en` is high and the user bit is 1, bits 11:8 are left unchanged. `priv_fault` is then 1 for exactly the next cycle and 0 in every other cycle.
- R5: On an integer compare (`cmp_en`=1, `cmp_is_fp`=0), bit 6 becomes 1 if `cmp_b` equals `cmp_a` and 0 otherwise.
- R6: On an integer compare, bit 2 becomes 1 if `cmp_b` is less than `cmp_a` as an unsigned value and 0 otherwise.
- R7: On an integer compare, bit 7 becomes 1 if `cmp_b` is less than `cmp_a` as a two's-complement value and 0 otherwise.
- R8: On a floating-point compare (`cmp_is_fp`=1), bit 6 takes `fp_eq`, bit 7 takes `fp_lt`, and bit 2 is cleared.
- R9: When `arith_en` is high, bit 0 takes `arith_carry`, where 1 means a carry or borrow occurred.
- R10: A compare or carry update in the same cycle as a low-byte write takes precedence for the bits it sets.
- R11: When `exc_entry` is high, bits 8, 9 and 1 become 0 on the next edge. This takes precedence over a write in the same cycle.
- R12: `irq_accept` equals `irq_req` while bit 11 is 1 and is 0 while bit 11 is 0. `nmi_accept` always equals `nmi_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo_en | input | 1 | Write the low byte |
| wr_hi_en | input | 1 | Write the high byte (supervisor only) |
| wr_data | input | 16 | Write data |
| cmp_en | input | 1 | Compare result valid |
| cmp_is_fp | input | 1 | Compare is floating point |
| cmp_a | input | OPW | First compare operand |
| cmp_b | input | OPW | Second compare operand |
| fp_eq | input | 1 | Floating-point equal result |
| fp_lt | input | 1 | Floating-point less result |
| arith_en | input | 1 | Add/subtract carry valid |
| arith_carry | input | 1 | Carry or borrow out |
| exc_entry | input | 1 | Interrupt or trap entry |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| psw | output | 16 | Status word |
| priv_fault | output | 1 | One-cycle pulse for a rejected high-byte write |
| irq_accept | output | 1 | Maskable request accepted |
| nmi_accept | output | 1 | Non-maskable request accepted |

## Verification
The assertions check the following on every cycle: the zero top nibble, the frozen high byte and the fault pulse after a user-mode write, the equal flag after integer compares, the cleared unsigned-less flag after float compares, the clearing done by exception entry, and the gating of interrupts. Only the bench's scenarios show the unsigned and signed less-than results at the sign boundary, where the two flags disagree. The same holds for the precedence of flag updates over a simultaneous low-byte write, and for the return from user mode to supervisor mode through exception entry.

// File: rtl/psw_pkg.sv
package psw_pkg;
   localparam int unsigned PSW_W   = 16;
   localparam int unsigned KEEP_W  = 12;
   localparam int B_CRY = 0;
   localparam int B_TRC = 1;
   localparam int B_ULT = 2;
   localparam int B_FLG = 5;
   localparam int B_EQ  = 6;
   localparam int B_SLT = 7;
   localparam int B_USR = 8;
   localparam int B_STK = 9;
   localparam int B_TPD = 10;
   localparam int B_IEN = 11;

   typedef struct packed {
      logic eq;
      logic ult;
      logic slt;
   } cmp_flags_t;
endpackage

// File: rtl/psw_cmp.sv
module psw_cmp
   import psw_pkg::*;
#(
   parameter int unsigned OPW     = 32,
   parameter bit          USE_SUB = 1'b1
) (
   input  logic [OPW-1:0] op_a,
   input  logic [OPW-1:0] op_b,
   input  logic           is_fp,
   input  logic           fp_eq,
   input  logic           fp_lt,
   output cmp_flags_t     flags
);
   localparam int unsigned MSB = OPW - 1;

   cmp_flags_t int_f;

   generate
      if (USE_SUB) begin : g_sub
         logic [OPW:0] diff;
         logic         ovf;
         always_comb begin
            diff      = {1'b0, op_b} - {1'b0, op_a};
            ovf       = (op_b[MSB] != op_a[MSB]) && (diff[MSB] != op_b[MSB]);
            int_f.eq  = (diff[MSB:0] == '0);
            int_f.ult = diff[OPW];
            int_f.slt = diff[MSB] ^ ovf;
         end
      end else begin : g_direct
         always_comb begin
            int_f.eq  = (op_b == op_a);
            int_f.ult = (op_b < op_a);
            int_f.slt = ($signed(op_b) < $signed(op_a));
         end
      end
   endgenerate

   always_comb begin
      if (is_fp) begin
         flags.eq  = fp_eq;
         flags.ult = 1'b0;
         flags.slt = fp_lt;
      end else begin
         flags = int_f;
      end
   end
endmodule

// File: rtl/psw_irq.sv
module psw_irq (
   input  logic ien,
   input  logic irq_req,
   input  logic nmi_req,
   output logic irq_accept,
   output logic nmi_accept
);
   assign irq_accept = irq_req & ien;
   assign nmi_accept = nmi_req;
endmodule

// File: rtl/psw_guard.sv
module psw_guard
   import psw_pkg::*;
#(
   parameter int unsigned OPW     = 32,
   parameter bit          USE_SUB = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_lo_en,
   input  logic           wr_hi_en,
   input  logic [15:0]    wr_data,
   input  logic           cmp_en,
   input  logic           cmp_is_fp,
   input  logic [OPW-1:0] cmp_a,
   input  logic [OPW-1:0] cmp_b,
   input  logic           fp_eq,
   input  logic           fp_lt,
   input  logic           arith_en,
   input  logic           arith_carry,
   input  logic           exc_entry,
   input  logic           irq_req,
   input  logic           nmi_req,
   output logic [15:0]    psw,
   output logic           priv_fault,
   output logic           irq_accept,
   output logic           nmi_accept
);
   localparam int unsigned PAD_W = PSW_W - KEEP_W;

   generate
      if (OPW < 2) begin : g_bad_opw
         $error("psw_guard: OPW must be at least 2");
      end
   endgenerate

   logic [KEEP_W-1:0] st_q, st_d;
   logic              fault_q;
   cmp_flags_t        cf;

   psw_cmp #(.OPW(OPW), .USE_SUB(USE_SUB)) u_cmp (
      .op_a  (cmp_a),
      .op_b  (cmp_b),
      .is_fp (cmp_is_fp),
      .fp_eq (fp_eq),
      .fp_lt (fp_lt),
      .flags (cf)
   );

   psw_irq u_irq (
      .ien        (st_q[B_IEN]),
      .irq_req    (irq_req),
      .nmi_req    (nmi_req),
      .irq_accept (irq_accept),
      .nmi_accept (nmi_accept)
   );

   always_comb begin
      st_d = st_q;
      if (wr_lo_en) st_d[7:0] = wr_data[7:0];
      if (wr_hi_en && !st_q[B_USR]) st_d[KEEP_W-1:8] = wr_data[KEEP_W-1:8];
      if (cmp_en) begin
         st_d[B_EQ]  = cf.eq;
         st_d[B_ULT] = cf.ult;
         st_d[B_SLT] = cf.slt;
      end
      if (arith_en) st_d[B_CRY] = arith_carry;
      if (exc_entry) begin
         st_d[B_USR] = 1'b0;
         st_d[B_STK] = 1'b0;
         st_d[B_TRC] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= '0;
         fault_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         fault_q <= wr_hi_en & st_q[B_USR];
      end
   end

   assign psw        = {{PAD_W{1'b0}}, st_q};
   assign priv_fault = fault_q;
endmodule

// File: rtl/psw_guard_chk.sv
module psw_guard_chk #(
   parameter int unsigned OPW = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_hi_en,
   input logic           cmp_en,
   input logic           cmp_is_fp,
   input logic [OPW-1:0] cmp_a,
   input logic [OPW-1:0] cmp_b,
   input logic           exc_entry,
   input logic           irq_req,
   input logic           nmi_req,
   input logic [15:0]    psw,
   input logic           priv_fault,
   input logic           irq_accept,
   input logic           nmi_accept
);
   a_r3_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      psw[15:12] == 4'h0);

   a_r4_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_en && psw[8] && !exc_entry) |=> $stable(psw[11:8]));

   a_r4_fault_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_en && psw[8]) |=> priv_fault);

   a_r4_fault_clr: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hi_en && psw[8]) |=> !priv_fault);

   a_r5_eq_set: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && !cmp_is_fp && cmp_a == cmp_b) |=> psw[6]);

   a_r5_eq_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && !cmp_is_fp && cmp_a != cmp_b) |=> !psw[6]);

   a_r8_fp_ult_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && cmp_is_fp) |=> !psw[2]);

   a_r11_entry_clear: assert property (@(posedge clk) disable iff (!rst_n)
      exc_entry |=> (!psw[8] && !psw[9] && !psw[1]));

   a_r12_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept |-> (irq_req && psw[11]));

   a_r12_irq_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && psw[11]) |-> irq_accept);

   a_r12_nmi: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_accept == nmi_req);
endmodule

bind psw_guard psw_guard_chk #(.OPW(OPW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_hi_en   (wr_hi_en),
   .cmp_en     (cmp_en),
   .cmp_is_fp  (cmp_is_fp),
   .cmp_a      (cmp_a),
   .cmp_b      (cmp_b),
   .exc_entry  (exc_entry),
   .irq_req    (irq_req),
   .nmi_req    (nmi_req),
   .psw        (psw),
   .priv_fault (priv_fault),
   .irq_accept (irq_accept),
   .nmi_accept (nmi_accept)
);

// File: tb/psw_guard_tb.sv
module psw_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_lo_en = 1'b0, wr_hi_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        cmp_en = 1'b0, cmp_is_fp = 1'b0;
   logic [31:0] cmp_a = '0, cmp_b = '0;
   logic        fp_eq = 1'b0, fp_lt = 1'b0;
   logic        arith_en = 1'b0, arith_carry = 1'b0;
   logic        exc_entry = 1'b0, irq_req = 1'b0, nmi_req = 1'b0;
   logic [15:0] psw;
   logic        priv_fault, irq_accept, nmi_accept;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_psw = '0;

   logic [15:0] q_psw[$];
   logic        q_flt[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   psw_guard u_dut (
      .clk(clk), .rst_n(rst_n), .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en),
      .wr_data(wr_data), .cmp_en(cmp_en), .cmp_is_fp(cmp_is_fp),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .fp_eq(fp_eq), .fp_lt(fp_lt),
      .arith_en(arith_en), .arith_carry(arith_carry), .exc_entry(exc_entry),
      .irq_req(irq_req), .nmi_req(nmi_req), .psw(psw),
      .priv_fault(priv_fault), .irq_accept(irq_accept), .nmi_accept(nmi_accept)
   );

   task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expected items and compares away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (q_psw.size() > 0) begin
            logic [15:0] ep;
            logic        ef;
            string       t;
            ep = q_psw.pop_front();
            ef = q_flt.pop_front();
            t  = q_tag.pop_front();
            chk(psw == ep, t, psw, ep);
            chk(priv_fault == ef, {t, " fault"}, {15'd0, priv_fault}, {15'd0, ef});
         end
      end
   end

   // driver: computes the expected word from the requirements and pushes it
   task automatic tick(string tag);
      logic [15:0] e;
      logic        f;
      e = m_psw;
      if (wr_lo_en) e[7:0] = wr_data[7:0];
      if (wr_hi_en && !m_psw[8]) e[11:8] = wr_data[11:8];
      if (cmp_en) begin
         if (cmp_is_fp) begin
            e[6] = fp_eq; e[2] = 1'b0; e[7] = fp_lt;
         end else begin
            e[6] = (cmp_b == cmp_a);
            e[2] = (cmp_b < cmp_a);
            e[7] = ($signed(cmp_b) < $signed(cmp_a));
         end
      end
      if (arith_en) e[0] = arith_carry;
      if (exc_entry) begin
         e[8] = 1'b0; e[9] = 1'b0; e[1] = 1'b0;
      end
      e[15:12] = 4'h0;
      f = wr_hi_en && m_psw[8];
      @(posedge clk);
      #1;
      wr_lo_en = 0; wr_hi_en = 0; cmp_en = 0; cmp_is_fp = 0;
      arith_en = 0; exc_entry = 0;
      q_psw.push_back(e); q_flt.push_back(f); q_tag.push_back(tag);
      m_psw = e;
      @(negedge clk);
   endtask

   task automatic icmp(logic [31:0] a, logic [31:0] b, string tag);
      cmp_en = 1; cmp_is_fp = 0; cmp_a = a; cmp_b = b;
      tick(tag);
   endtask

   task automatic irq_chk(logic ir, logic nr, logic ei, logic en, string tag);
      irq_req = ir; nmi_req = nr;
      #1;
      chk(irq_accept == ei, {tag, " irq"}, {15'd0, irq_accept}, {15'd0, ei});
      chk(nmi_accept == en, {tag, " nmi"}, {15'd0, nmi_accept}, {15'd0, en});
      irq_req = 0; nmi_req = 0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(psw == 16'h0, "R1 reset psw", psw, 16'h0);
      chk(priv_fault == 1'b0, "R1 reset fault", {15'd0, priv_fault}, 16'h0);
      rst_n = 1;
      @(negedge clk);

      wr_lo_en = 1; wr_data = 16'h00A5; tick("R2 low write");
      wr_hi_en = 1; wr_data = 16'hF800; tick("R3 supervisor high write, top nibble zero");
      icmp(32'd5, 32'd3, "R5 R6 R7 small operands");
      icmp(32'hFFFF_FFFF, 32'd1, "R6 R7 unsigned less, signed greater");
      icmp(32'd1, 32'hFFFF_FFFF, "R6 R7 signed less, unsigned greater");
      icmp(32'h8000_0000, 32'h7FFF_FFFF, "R6 R7 sign boundary");
      icmp(32'h1234_5678, 32'h1234_5678, "R5 equal operands");
      cmp_en = 1; cmp_is_fp = 1; fp_eq = 0; fp_lt = 1; tick("R8 float less");
      cmp_en = 1; cmp_is_fp = 1; fp_eq = 1; fp_lt = 0; tick("R8 float equal");
      arith_en = 1; arith_carry = 1; tick("R9 carry set");
      arith_en = 1; arith_carry = 0; tick("R9 carry clear");
      wr_lo_en = 1; wr_data = 16'h00FF; cmp_en = 1; cmp_a = 32'd7; cmp_b = 32'd7;
      arith_en = 1; arith_carry = 0; tick("R10 flag update over low write");

      irq_chk(1, 0, 1, 0, "R12 enabled maskable");
      irq_chk(1, 1, 1, 1, "R12 enabled both");

      wr_hi_en = 1; wr_data = 16'h0300; tick("R3 enter user mode, disable interrupts");
      irq_chk(1, 0, 0, 0, "R12 masked");
      irq_chk(0, 1, 0, 1, "R12 nmi while masked");

      wr_hi_en = 1; wr_data = 16'h0800; tick("R4 user high write ignored");
      tick("R4 fault lasts one cycle");
      wr_lo_en = 1; wr_data = 16'h0002; tick("R2 low write in user mode");
      exc_entry = 1; wr_lo_en = 1; wr_data = 16'h0002; wr_hi_en = 1;
      wr_data = 16'h0702; tick("R11 entry clears user, stack, trace");
      wr_hi_en = 1; wr_data = 16'h0C00; tick("R3 supervisor write after entry");
      irq_chk(1, 0, 1, 0, "R12 re-enabled");

      repeat (2) @(negedge clk);
      summary();
   end
endmodule